// File: doc/BRIEF.md
# Dirty-line flush writeback sequencer

This block sits beside the storage of a write-back data cache and, when a flush request arrives, walks every set and every way in ascending order, writing each line whose dirty flag is set back to memory. The stored tag and the full line travel on a memory write request with a ready/valid style handshake. Once memory acknowledges the write, the dirty flag of that line is cleared. Tags and line data are kept as they are, so the cache stays usable after the flush and simply holds clean copies.

The dirty flags live in flip-flops inside the block and are read combinationally for the set being visited. The tag and line storage has one cycle of read latency. A one-cycle load step is therefore spent at the start of each set. Two host ports update the storage. A line write port fills tag, data and dirty flag at once, as a refill does. A mark port only raises a dirty flag, as an ordinary store does. The stall output stays high for the whole walk, so the pipeline freezes until every dirty line has reached memory.

Top module: `flush_writeback_seq`

## Requirements
- R1: After reset, `stall` and `wb_valid` are low, and every dirty flag is clear.
- R2: A walk starts only on a rising edge of `flush_req`. When the walk ends, `stall` falls and stays low for as long as `flush_req` is held high, with no second walk. A new walk needs `flush_req` to drop and rise again.
- R3: If no line is dirty, `wb_valid` stays low for the whole walk, and `stall` is high for exactly SETS*(1+2*WAYS) cycles.
- R4: Every dirty line is written exactly once. Lines go out in ascending set order and, within a set, in ascending way order. `wb_addr` is {stored tag, set index, zero byte offset} and `wb_data` is the full stored line.
- R5: Once raised, `wb_valid` stays high with `wb_addr` and `wb_data` stable through the cycle in which `wb_ready` is seen. It then stays high until `wb_ack` is seen, and drops the cycle after that.
- R6: A line written back during a walk has its dirty flag cleared. A following walk with no new stores writes nothing.
- R7: A walk leaves tags and line data unchanged. A line marked dirty again through the mark port is written back with its earlier tag and data.
- R8: With dirty lines present, the stall length equals SETS*(1+2*WAYS), plus the number of cycles `wb_valid` is high, plus one per dirty line.
- R9: A line write with `line_dirty` low leaves that line clean, even if it was dirty before, so it is not written back. When the line write port and the mark port hit the same line in one cycle, the line write decides the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush_req | input | 1 | Flush request; its rising edge starts a walk |
| stall | output | 1 | High while a walk is in progress |
| line_we | input | 1 | Line write strobe (tag, data and dirty flag) |
| line_set | input | SET_W (4) | Set index of the line write |
| line_way | input | WAY_W (2) | Way of the line write |
| line_tag | input | TAG_W (24) | Tag stored by the line write |
| line_data | input | LINE_BITS (128) | Line stored by the line write |
| line_dirty | input | 1 | Dirty flag stored by the line write |
| mark_we | input | 1 | Store strobe that sets a dirty flag |
| mark_set | input | SET_W (4) | Set index of the store |
| mark_way | input | WAY_W (2) | Way of the store |
| wb_valid | output | 1 | Memory write request |
| wb_addr | output | ADDR_W (32) | Line-aligned writeback address |
| wb_data | output | LINE_BITS (128) | Line being written back |
| wb_ready | input | 1 | Memory accepts the request |
| wb_ack | input | 1 | Memory reports the write complete |

## Verification
Four walk patterns are used. A walk over clean lines pins the bare scan length and shows the request line stays silent. A walk over lines filled in a scrambled order, including the first and last way of a set and the very last line, tells scan order apart from fill order and catches off-by-one limits on the set and way counters. An immediate second walk separates a real dirty-flag clear from a mere skip. Re-marking lines through the store port then separates tag and data retention from a clear of those arrays. Memory ready and acknowledge delays change from line to line, so the stall-length formula shows whether the handshake waits are counted correctly.

// File: rtl/flushwb_pkg.sv
package flushwb_pkg;

   // Walk sequencer states
   typedef enum logic [2:0] {
      S_IDLE,   // waiting for a flush edge
      S_LOAD,   // one cycle for the storage read of the new set
      S_PROBE,  // test the dirty flag of the current way
      S_ISSUE,  // request raised, waiting for memory ready
      S_AWAIT,  // request held, waiting for write completion
      S_CLEAN,  // clear the flag of the written line
      S_STEP,   // advance way / set
      S_DONE    // walk finished, waiting for the request to drop
   } walk_state_e;

endpackage

// File: rtl/dirty_flags.sv
module dirty_flags #(
   parameter int SETS  = 16,
   parameter int WAYS  = 4,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   // line write port: stores the given flag value (highest priority)
   input  logic             fill_we,
   input  logic [SET_W-1:0] fill_set,
   input  logic [WAY_W-1:0] fill_way,
   input  logic             fill_val,
   // store port: sets the flag
   input  logic             mark_we,
   input  logic [SET_W-1:0] mark_set,
   input  logic [WAY_W-1:0] mark_way,
   // sequencer port: clears the flag
   input  logic             clr_en,
   input  logic [SET_W-1:0] clr_set,
   input  logic [WAY_W-1:0] clr_way,
   // combinational read of a whole set
   input  logic [SET_W-1:0] rd_set,
   output logic [WAYS-1:0]  rd_bits
);

   logic [WAYS-1:0] flags_q [SETS];

   for (genvar s = 0; s < SETS; s++) begin : g_set
      for (genvar w = 0; w < WAYS; w++) begin : g_way
         logic hit_fill, hit_mark, hit_clr;
         assign hit_fill = fill_we && (fill_set == SET_W'(s)) && (fill_way == WAY_W'(w));
         assign hit_mark = mark_we && (mark_set == SET_W'(s)) && (mark_way == WAY_W'(w));
         assign hit_clr  = clr_en  && (clr_set  == SET_W'(s)) && (clr_way  == WAY_W'(w));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        flags_q[s][w] <= 1'b0;
            else if (hit_fill) flags_q[s][w] <= fill_val;
            else if (hit_mark) flags_q[s][w] <= 1'b1;
            else if (hit_clr)  flags_q[s][w] <= 1'b0;
         end
      end
   end

   assign rd_bits = flags_q[rd_set];

endmodule

// File: rtl/line_store.sv
module line_store #(
   parameter int SETS   = 16,
   parameter int TAG_W  = 24,
   parameter int LINE_W = 128,
   localparam int SET_W = $clog2(SETS)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [SET_W-1:0]  wr_set,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [LINE_W-1:0] wr_data,
   input  logic [SET_W-1:0]  rd_set,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [LINE_W-1:0] rd_data
);

   logic [TAG_W-1:0]  tag_mem  [SETS];
   logic [LINE_W-1:0] data_mem [SETS];

   always_ff @(posedge clk) begin
      if (we) begin
         tag_mem[wr_set]  <= wr_tag;
         data_mem[wr_set] <= wr_data;
      end
   end

   // registered read: one cycle of latency
   always_ff @(posedge clk) begin
      rd_tag  <= tag_mem[rd_set];
      rd_data <= data_mem[rd_set];
   end

endmodule

// File: rtl/walk_fsm.sv
module walk_fsm
   import flushwb_pkg::*;
#(
   parameter int SETS  = 16,
   parameter int WAYS  = 4,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS),
   localparam logic [SET_W-1:0] LAST_SET = SET_W'(SETS - 1),
   localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_req,
   input  logic             cur_dirty,
   input  logic             mem_ready,
   input  logic             mem_ack,
   output logic [SET_W-1:0] set_q,
   output logic [WAY_W-1:0] way_q,
   output logic             busy,
   output logic             issue,
   output logic             clean_en
);

   walk_state_e      state_q, state_d;
   logic [SET_W-1:0] set_d;
   logic [WAY_W-1:0] way_d;
   logic             flush_d1;
   logic             start;

   assign start = flush_req && !flush_d1;

   always_comb begin
      state_d = state_q;
      set_d   = set_q;
      way_d   = way_q;
      unique case (state_q)
         S_IDLE:  if (start) begin
                     state_d = S_LOAD;
                     set_d   = '0;
                     way_d   = '0;
                  end
         S_LOAD:  state_d = S_PROBE;
         S_PROBE: state_d = cur_dirty ? S_ISSUE : S_STEP;
         S_ISSUE: if (mem_ready) state_d = S_AWAIT;
         S_AWAIT: if (mem_ack)   state_d = S_CLEAN;
         S_CLEAN: state_d = S_STEP;
         S_STEP:  if (way_q != LAST_WAY) begin
                     way_d   = way_q + 1'b1;
                     state_d = S_PROBE;
                  end else if (set_q != LAST_SET) begin
                     set_d   = set_q + 1'b1;
                     way_d   = '0;
                     state_d = S_LOAD;
                  end else begin
                     state_d = S_DONE;
                  end
         S_DONE:  if (!flush_req) state_d = S_IDLE;
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= S_IDLE;
         set_q    <= '0;
         way_q    <= '0;
         flush_d1 <= 1'b0;
      end else begin
         state_q  <= state_d;
         set_q    <= set_d;
         way_q    <= way_d;
         flush_d1 <= flush_req;
      end
   end

   assign busy     = (state_q != S_IDLE) && (state_q != S_DONE);
   assign issue    = (state_q == S_ISSUE) || (state_q == S_AWAIT);
   assign clean_en = (state_q == S_CLEAN);

   // R2: a flush edge seen while idle starts the walk on the next cycle
   p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_IDLE && flush_req && !flush_d1) |=> busy);

   // R2: the finished state is held without stall while the request stays high
   p_done_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_DONE && flush_req) |=> (state_q == S_DONE && !busy));

   // R5: a request awaiting ready or ack keeps its owner state
   p_issue_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && !mem_ack) |=> issue);

endmodule

// File: rtl/flush_writeback_seq.sv
module flush_writeback_seq #(
   parameter int ADDR_W      = 32,
   parameter int LINE_BITS   = 128,
   parameter int CACHE_BYTES = 1024,
   parameter int WAYS        = 4,
   localparam int LINE_BYTES = LINE_BITS / 8,
   localparam int SETS       = CACHE_BYTES / LINE_BYTES / WAYS,
   localparam int SET_W      = $clog2(SETS),
   localparam int WAY_W      = $clog2(WAYS),
   localparam int OFF_W      = $clog2(LINE_BYTES),
   localparam int TAG_W      = ADDR_W - SET_W - OFF_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 flush_req,
   output logic                 stall,
   input  logic                 line_we,
   input  logic [SET_W-1:0]     line_set,
   input  logic [WAY_W-1:0]     line_way,
   input  logic [TAG_W-1:0]     line_tag,
   input  logic [LINE_BITS-1:0] line_data,
   input  logic                 line_dirty,
   input  logic                 mark_we,
   input  logic [SET_W-1:0]     mark_set,
   input  logic [WAY_W-1:0]     mark_way,
   output logic                 wb_valid,
   output logic [ADDR_W-1:0]    wb_addr,
   output logic [LINE_BITS-1:0] wb_data,
   input  logic                 wb_ready,
   input  logic                 wb_ack
);

   // elaboration-time parameter checks
   if (LINE_BITS < 32 || (LINE_BITS & (LINE_BITS - 1)) != 0) begin : g_bad_line
      $error("LINE_BITS must be a power of two of at least 32");
   end
   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("CACHE_BYTES must give a power-of-two set count of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("address too narrow for the chosen geometry");
   end

   logic [SET_W-1:0]     cur_set;
   logic [WAY_W-1:0]     cur_way;
   logic [WAYS-1:0]      set_dirty;
   logic                 sel_dirty;
   logic                 clean_en;
   logic [TAG_W-1:0]     rd_tag  [WAYS];
   logic [LINE_BITS-1:0] rd_data [WAYS];
   logic [TAG_W-1:0]     sel_tag;
   logic [LINE_BITS-1:0] sel_data;

   dirty_flags #(.SETS(SETS), .WAYS(WAYS)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .fill_we  (line_we),
      .fill_set (line_set),
      .fill_way (line_way),
      .fill_val (line_dirty),
      .mark_we  (mark_we),
      .mark_set (mark_set),
      .mark_way (mark_way),
      .clr_en   (clean_en),
      .clr_set  (cur_set),
      .clr_way  (cur_way),
      .rd_set   (cur_set),
      .rd_bits  (set_dirty)
   );

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      line_store #(.SETS(SETS), .TAG_W(TAG_W), .LINE_W(LINE_BITS)) u_store (
         .clk     (clk),
         .we      (line_we && (line_way == WAY_W'(w))),
         .wr_set  (line_set),
         .wr_tag  (line_tag),
         .wr_data (line_data),
         .rd_set  (cur_set),
         .rd_tag  (rd_tag[w]),
         .rd_data (rd_data[w])
      );
   end

   walk_fsm #(.SETS(SETS), .WAYS(WAYS)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush_req (flush_req),
      .cur_dirty (sel_dirty),
      .mem_ready (wb_ready),
      .mem_ack   (wb_ack),
      .set_q     (cur_set),
      .way_q     (cur_way),
      .busy      (stall),
      .issue     (wb_valid),
      .clean_en  (clean_en)
   );

   assign sel_dirty = set_dirty[cur_way];

   always_comb begin
      sel_tag  = '0;
      sel_data = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (cur_way == WAY_W'(w)) begin
            sel_tag  = rd_tag[w];
            sel_data = rd_data[w];
         end
      end
   end

   assign wb_addr = {sel_tag, cur_set, {OFF_W{1'b0}}};
   assign wb_data = sel_data;

   // R3: no memory request outside a walk
   p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !stall |-> !wb_valid);

   // R4: a request only starts on a line whose flag was set
   p_only_dirty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wb_valid) |-> $past(sel_dirty));

   // R5: address and data hold while the request is outstanding
   p_req_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !wb_ack) |=> (wb_valid && $stable(wb_addr) && $stable(wb_data)));

   // R6: after the clean step the visited line reads clean
   p_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clean_en && !line_we && !mark_we) |=> !sel_dirty);

endmodule

// File: tb/tb_flush_writeback_seq.sv
`timescale 1ns/1ps
module tb_flush_writeback_seq;

   localparam int ADDR_W = 32, LINE_BITS = 128, CACHE_BYTES = 1024, WAYS = 4;
   localparam int LINE_BYTES = LINE_BITS / 8;
   localparam int SETS  = CACHE_BYTES / LINE_BYTES / WAYS;
   localparam int SET_W = $clog2(SETS);
   localparam int WAY_W = $clog2(WAYS);
   localparam int OFF_W = $clog2(LINE_BYTES);
   localparam int TAG_W = ADDR_W - SET_W - OFF_W;
   localparam int SCAN_LEN = SETS * (1 + 2 * WAYS);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush_req = 1'b0;
   logic stall;
   logic line_we = 1'b0;
   logic [SET_W-1:0] line_set = '0;
   logic [WAY_W-1:0] line_way = '0;
   logic [TAG_W-1:0] line_tag = '0;
   logic [LINE_BITS-1:0] line_data = '0;
   logic line_dirty = 1'b0;
   logic mark_we = 1'b0;
   logic [SET_W-1:0] mark_set = '0;
   logic [WAY_W-1:0] mark_way = '0;
   logic wb_valid;
   logic [ADDR_W-1:0] wb_addr;
   logic [LINE_BITS-1:0] wb_data;
   logic wb_ready = 1'b0;
   logic wb_ack = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   flush_writeback_seq #(.ADDR_W(ADDR_W), .LINE_BITS(LINE_BITS),
                         .CACHE_BYTES(CACHE_BYTES), .WAYS(WAYS)) dut (
      .clk(clk), .rst_n(rst_n), .flush_req(flush_req), .stall(stall),
      .line_we(line_we), .line_set(line_set), .line_way(line_way),
      .line_tag(line_tag), .line_data(line_data), .line_dirty(line_dirty),
      .mark_we(mark_we), .mark_set(mark_set), .mark_way(mark_way),
      .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data),
      .wb_ready(wb_ready), .wb_ack(wb_ack)
   );

   int total = 0;
   int bad   = 0;

   task automatic check(bit ok, string req, string what,
                        logic [159:0] act, logic [159:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // reference model of the cache contents
   logic [TAG_W-1:0]     m_tag   [SETS][WAYS];
   logic [LINE_BITS-1:0] m_data  [SETS][WAYS];
   bit                   m_dirty [SETS][WAYS];

   typedef struct {
      logic [ADDR_W-1:0]    addr;
      logic [LINE_BITS-1:0] data;
   } wb_item_t;
   wb_item_t exp_q[$];

   function automatic logic [LINE_BITS-1:0] mk_data(int s, int w, int salt);
      return {32'(salt), 32'(s), 32'(w), 32'hC0DE0000 ^ 32'(s * 8 + w)};
   endfunction
   function automatic logic [TAG_W-1:0] mk_tag(int s, int w, int salt);
      return TAG_W'(32'h3A0000 + s * 37 + w * 5 + salt * 11);
   endfunction

   // driver: refill-style line write
   task automatic write_line(int s, int w, int salt, bit d);
      @(negedge clk);
      line_we = 1'b1; line_set = SET_W'(s); line_way = WAY_W'(w);
      line_tag = mk_tag(s, w, salt); line_data = mk_data(s, w, salt); line_dirty = d;
      m_tag[s][w] = mk_tag(s, w, salt); m_data[s][w] = mk_data(s, w, salt); m_dirty[s][w] = d;
      @(negedge clk);
      line_we = 1'b0;
   endtask

   // driver: store marks a line dirty
   task automatic mark_line(int s, int w);
      @(negedge clk);
      mark_we = 1'b1; mark_set = SET_W'(s); mark_way = WAY_W'(w);
      m_dirty[s][w] = 1'b1;
      @(negedge clk);
      mark_we = 1'b0;
   endtask

   // monitor / memory responder with varying ready and ack delays
   int pace = 0;
   initial begin
      forever begin
         @(negedge clk);
         if (wb_valid) begin
            repeat (pace % 3) @(negedge clk);
            wb_ready = 1'b1;
            @(negedge clk);
            wb_ready = 1'b0;
            repeat ((pace + 1) % 3) @(negedge clk);
            check(wb_valid, "R5", "request held until ack", 160'(wb_valid), 160'(1));
            if (exp_q.size() == 0) begin
               check(1'b0, "R4", "unexpected writeback addr", 160'(wb_addr), 160'(0));
            end else begin
               wb_item_t it;
               it = exp_q.pop_front();
               check(wb_addr == it.addr, "R4", "writeback address", 160'(wb_addr), 160'(it.addr));
               check(wb_data == it.data, "R4", "writeback line", 160'(wb_data), 160'(it.data));
            end
            wb_ack = 1'b1;
            @(negedge clk);
            wb_ack = 1'b0;
            pace++;
         end
      end
   end

   // cycle counters
   bit counting = 1'b0;
   int stall_cnt = 0;
   int valid_cnt = 0;
   always @(negedge clk) begin
      if (counting) begin
         if (stall)    stall_cnt++;
         if (wb_valid) valid_cnt++;
      end
   end

   // one complete walk: builds expectations in scan order, then checks timing
   task automatic run_flush(string req, int exp_dirty);
      int nd = 0;
      for (int s = 0; s < SETS; s++) begin
         for (int w = 0; w < WAYS; w++) begin
            if (m_dirty[s][w]) begin
               wb_item_t it;
               it.addr = {m_tag[s][w], SET_W'(s), {OFF_W{1'b0}}};
               it.data = m_data[s][w];
               exp_q.push_back(it);
               m_dirty[s][w] = 1'b0;
               nd++;
            end
         end
      end
      check(nd == exp_dirty, req, "model dirty count", 160'(nd), 160'(exp_dirty));
      stall_cnt = 0; valid_cnt = 0; counting = 1'b1;
      @(negedge clk);
      flush_req = 1'b1;
      @(negedge clk);
      check(stall, "R2", "stall after flush edge", 160'(stall), 160'(1));
      while (stall) @(negedge clk);
      counting = 1'b0;
      check(exp_q.size() == 0, req, "lines left unwritten", 160'(exp_q.size()), 160'(0));
      if (nd == 0) begin
         // R3: clean walk
         check(valid_cnt == 0, "R3", "request cycles on clean walk", 160'(valid_cnt), 160'(0));
         check(stall_cnt == SCAN_LEN, "R3", "clean stall length", 160'(stall_cnt), 160'(SCAN_LEN));
      end else begin
         // R8: walk with writebacks
         check(stall_cnt == SCAN_LEN + valid_cnt + nd, "R8", "stall length",
               160'(stall_cnt), 160'(SCAN_LEN + valid_cnt + nd));
      end
      // R2: held request does not restart the walk
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (stall || wb_valid) begin
            check(1'b0, "R2", "restart while request held", 160'(stall), 160'(0));
            break;
         end
      end
      check(!stall, "R2", "stall low while request held", 160'(stall), 160'(0));
      flush_req = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   // watchdog
   initial begin
      #(20ns * 150000);
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int s = 0; s < SETS; s++)
         for (int w = 0; w < WAYS; w++) m_dirty[s][w] = 1'b0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(!stall, "R1", "stall in reset", 160'(stall), 160'(0));
      check(!wb_valid, "R1", "request in reset", 160'(wb_valid), 160'(0));
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!stall && !wb_valid, "R1", "idle after reset", 160'({stall, wb_valid}), 160'(0));

      // R3: clean lines only (reset flags all clear)
      write_line(2, 1, 1, 1'b0);
      write_line(14, 0, 1, 1'b0);
      run_flush("R3", 0);

      // R4 / R5 / R8 / R9: dirty lines filled out of scan order
      write_line(15, 3, 2, 1'b1);   // very last line of the walk
      write_line(7, 2, 2, 1'b1);
      write_line(0, 3, 2, 1'b1);
      write_line(0, 0, 2, 1'b1);
      write_line(9, 1, 2, 1'b1);
      write_line(5, 1, 2, 1'b1);
      write_line(5, 1, 3, 1'b0);    // R9: rewritten clean, must not be written
      // R9: same-cycle line write (clean) and mark on one line
      @(negedge clk);
      line_we = 1'b1; line_set = SET_W'(11); line_way = WAY_W'(2);
      line_tag = mk_tag(11, 2, 4); line_data = mk_data(11, 2, 4); line_dirty = 1'b0;
      mark_we = 1'b1; mark_set = SET_W'(11); mark_way = WAY_W'(2);
      m_tag[11][2] = mk_tag(11, 2, 4); m_data[11][2] = mk_data(11, 2, 4); m_dirty[11][2] = 1'b0;
      @(negedge clk);
      line_we = 1'b0; mark_we = 1'b0;
      run_flush("R4", 5);

      // R6: flags were cleared, nothing to write
      run_flush("R6", 0);

      // R7: re-mark lines, tag and data must be the retained ones
      mark_line(7, 2);
      mark_line(15, 3);
      mark_line(0, 0);
      run_flush("R7", 3);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule